// File: doc/BRIEF.md
# Time-Multiplexed Complex Beam Accumulator

This block forms beams from a serial stream of complex samples and complex weights, one sample/weight pair per clock. A single complex multiplier, made of four real multipliers, computes each product. A pipelined accumulator sums the products of one window, which is one beam. A restart flag that travels with the first pair of each window makes the accumulator load that product instead of adding it. The same hardware is reused for every beam of a snapshot: with the default sizes it forms 90 beams of 91 taps each, 8190 products per snapshot.

When the last tap of a window has been added, the block emits the complex beam sum, its power (re² + im²) and a beam index. All three appear together with a one-cycle valid pulse that is delayed to match the pipeline. A low input valid holds the pipeline position of the open window, so the window continues unharmed once data resumes. Address generation and coefficient storage sit upstream of this block, and transport of the results sits downstream.

Top module: `beam_mac_engine`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_idx, out_re, out_im and out_pwr are all cleared to zero.
- R2: Each product is the signed complex product of the sample and weight: re = s_re·w_re − s_im·w_im, im = s_re·w_im + s_im·w_re. A beam is the sum of exactly TAPS (default 91) valid products, counted from the product that carried the restart flag.
- R3: out_valid is high for exactly one cycle. It rises after the fourth rising edge, counting the edge that samples the last tap of the window as the first.
- R4: A pair with in_valid and in_first both high opens a new window and loads its product as the first term. This also applies in the middle of an open window, where the partial sum is discarded.
- R5: Cycles with in_valid low add nothing and do not advance the tap count. The open window completes with the correct sum after data resumes.
- R6: Valid pairs that arrive without in_first while no window is open are ignored and produce no output.
- R7: out_pwr equals out_re² + out_im² as an unsigned value, and is presented on the same cycle as the beam value.
- R8: out_idx is 0 for the first beam after reset and rises by one for each completed beam. It wraps from BEAMS−1 (default 89) back to 0.
- R9: With full-scale signed 16-bit inputs on all TAPS products, the beam sum is exact, with no wrap-around.
- R10: in_first has no effect on a cycle where in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample/weight pair is valid this cycle |
| in_first | input | 1 | Pair is the first term of a new window (only with in_valid) |
| smp_re | input | 16 | Sample real part, signed |
| smp_im | input | 16 | Sample imaginary part, signed |
| wgt_re | input | 16 | Weight real part, signed |
| wgt_im | input | 16 | Weight imaginary part, signed |
| out_valid | output | 1 | One-cycle pulse: beam result is valid |
| out_idx | output | 7 | Beam index, 0 to BEAMS−1 |
| out_re | output | 40 | Beam sum real part, signed |
| out_im | output | 40 | Beam sum imaginary part, signed |
| out_pwr | output | 80 | Beam power re² + im², unsigned |

## Verification
Two of the block's functions meet in the same cycle when windows run back to back. The accumulator closes one beam, capturing its sum and raising the index, on the same edge that the restart product of the next beam reaches it. If the restart is mishandled, the new beam carries over the old sum or loses its first term. The bench provokes this with a run of more than BEAMS contiguous windows of random data, which also forces the index to wrap. It also places a restart in the middle of an open window and mixes in stall cycles that carry a stray restart flag. Every cycle is judged against a behavioural model: the output valid, both beam parts, the power and the index must match the model exactly.

// File: rtl/bmac_pkg.sv
// Package: shared types for the beam accumulator.
package bmac_pkg;
    // State of the accumulation window
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;
endpackage

// File: rtl/bmac_cmul.sv
// Module: bmac_cmul
// Two-stage signed complex multiplier made of four real multipliers.
// Stage 1 registers the four partial products; stage 2 combines them.
// Assumes: flags are only meaningful when in_valid is high; in_first is
// qualified by in_valid here, so a stray flag never reaches the accumulator.
module bmac_cmul #(
    parameter int DATA_W = 16,
    parameter int WGT_W  = 16,
    localparam int PROD_W = DATA_W + WGT_W,
    localparam int CPLX_W = PROD_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_first,
    input  logic signed [DATA_W-1:0] s_re,
    input  logic signed [DATA_W-1:0] s_im,
    input  logic signed [WGT_W-1:0]  w_re,
    input  logic signed [WGT_W-1:0]  w_im,
    output logic                     p_valid,
    output logic                     p_first,
    output logic signed [CPLX_W-1:0] p_re,
    output logic signed [CPLX_W-1:0] p_im
);
    logic                     v1, f1;
    logic signed [PROD_W-1:0] m_rr, m_ii, m_ri, m_ir;

    // Stage 1: four real products and qualified control flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1   <= 1'b0;
            f1   <= 1'b0;
            m_rr <= '0;
            m_ii <= '0;
            m_ri <= '0;
            m_ir <= '0;
        end else begin
            v1 <= in_valid;
            f1 <= in_valid & in_first;
            if (in_valid) begin
                m_rr <= s_re * w_re;
                m_ii <= s_im * w_im;
                m_ri <= s_re * w_im;
                m_ir <= s_im * w_re;
            end
        end
    end

    // Stage 2: combine into real and imaginary product, one bit wider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_first <= 1'b0;
            p_re    <= '0;
            p_im    <= '0;
        end else begin
            p_valid <= v1;
            p_first <= f1;
            if (v1) begin
                p_re <= {m_rr[PROD_W-1], m_rr} - {m_ii[PROD_W-1], m_ii};
                p_im <= {m_ri[PROD_W-1], m_ri} + {m_ir[PROD_W-1], m_ir};
            end
        end
    end

    // R10
    restart_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !f1);
    // R2
    product_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v1 |=> $stable(p_re) && $stable(p_im));
endmodule

// File: rtl/bmac_accum.sv
// Module: bmac_accum
// Window accumulator with restart control. A product flagged first loads
// the accumulator; later valid products add to it until TAPS terms are in,
// then the sum and a beam index are captured with a one-cycle done pulse.
// Assumes: ACC_W leaves room for TAPS full-scale products; BEAMS >= 2.
module bmac_accum
    import bmac_pkg::*;
#(
    parameter int CPLX_W = 33,
    parameter int TAPS   = 91,
    parameter int BEAMS  = 90,
    localparam int ACC_W = CPLX_W + $clog2(TAPS),
    localparam int CNT_W = $clog2(TAPS + 1),
    localparam int IDX_W = $clog2(BEAMS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     p_valid,
    input  logic                     p_first,
    input  logic signed [CPLX_W-1:0] p_re,
    input  logic signed [CPLX_W-1:0] p_im,
    output logic                     done,
    output logic signed [ACC_W-1:0]  beam_re,
    output logic signed [ACC_W-1:0]  beam_im,
    output logic [IDX_W-1:0]         beam_idx
);
    win_state_e              state, state_nx;
    logic [CNT_W-1:0]        cnt, cnt_nx;
    logic signed [ACC_W-1:0] acc_re, acc_im, acc_re_nx, acc_im_nx;
    logic signed [ACC_W-1:0] x_re, x_im;
    logic                    take, close;
    logic [IDX_W-1:0]        idx;

    // Sign-extend the incoming product to accumulator width
    always_comb begin
        x_re = {{(ACC_W-CPLX_W){p_re[CPLX_W-1]}}, p_re};
        x_im = {{(ACC_W-CPLX_W){p_im[CPLX_W-1]}}, p_im};
    end

    // Next-state: load on restart, add while open, close at TAPS terms
    always_comb begin
        state_nx  = state;
        cnt_nx    = cnt;
        acc_re_nx = acc_re;
        acc_im_nx = acc_im;
        take      = 1'b0;
        if (p_valid && p_first) begin
            take      = 1'b1;
            cnt_nx    = CNT_W'(1);
            acc_re_nx = x_re;
            acc_im_nx = x_im;
        end else if (p_valid && state == WIN_OPEN) begin
            take      = 1'b1;
            cnt_nx    = cnt + CNT_W'(1);
            acc_re_nx = acc_re + x_re;
            acc_im_nx = acc_im + x_im;
        end
        close = take && (cnt_nx == CNT_W'(TAPS));
        if (take) state_nx = close ? WIN_IDLE : WIN_OPEN;
    end

    // Window registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WIN_IDLE;
            cnt    <= '0;
            acc_re <= '0;
            acc_im <= '0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            acc_re <= acc_re_nx;
            acc_im <= acc_im_nx;
        end
    end

    // Capture the finished beam and advance the wrapping beam index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            beam_re  <= '0;
            beam_im  <= '0;
            beam_idx <= '0;
            idx      <= '0;
        end else begin
            done <= close;
            if (close) begin
                beam_re  <= acc_re_nx;
                beam_im  <= acc_im_nx;
                beam_idx <= idx;
                idx      <= (idx == IDX_W'(BEAMS - 1)) ? '0 : idx + IDX_W'(1);
            end
        end
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_valid |=> $stable(acc_re) && $stable(acc_im) && $stable(cnt));
    // R4
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid && p_first |=> cnt == CNT_W'(1));
    // R2
    tap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(TAPS));
    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(BEAMS - 1));
endmodule

// File: rtl/bmac_power.sv
// Module: bmac_power
// Output stage: registers the beam value and index and computes the
// unsigned power re^2 + im^2 in the same cycle, with a matching valid pulse.
// Assumes: inputs hold steady between done pulses.
module bmac_power #(
    parameter int ACC_W = 40,
    parameter int IDX_W = 7,
    localparam int PWR_W = 2 * ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    done,
    input  logic signed [ACC_W-1:0] beam_re,
    input  logic signed [ACC_W-1:0] beam_im,
    input  logic [IDX_W-1:0]        beam_idx,
    output logic                    out_valid,
    output logic [IDX_W-1:0]        out_idx,
    output logic signed [ACC_W-1:0] out_re,
    output logic signed [ACC_W-1:0] out_im,
    output logic [PWR_W-1:0]        out_pwr
);
    logic signed [PWR_W-1:0] ext_re, ext_im;
    logic [PWR_W-1:0]        sum_sq;

    // Widen both parts and form the sum of squares
    always_comb begin
        ext_re = {{ACC_W{beam_re[ACC_W-1]}}, beam_re};
        ext_im = {{ACC_W{beam_im[ACC_W-1]}}, beam_im};
        sum_sq = PWR_W'(ext_re * ext_re) + PWR_W'(ext_im * ext_im);
    end

    // Output registers, updated on each finished beam
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_re    <= '0;
            out_im    <= '0;
            out_pwr   <= '0;
        end else begin
            out_valid <= done;
            if (done) begin
                out_idx <= beam_idx;
                out_re  <= beam_re;
                out_im  <= beam_im;
                out_pwr <= sum_sq;
            end
        end
    end

    // R7
    beam_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> out_valid && out_re == $past(beam_re) && out_im == $past(beam_im));
endmodule

// File: rtl/beam_mac_engine.sv
// Module: beam_mac_engine
// Time-multiplexed complex beam accumulator: one shared complex multiplier,
// a restart-controlled window accumulator and a power stage. Latency from
// the sampling edge of the last tap to visible output is four edges.
// Assumes: the upstream source sets in_first on the first pair of each beam.
module beam_mac_engine #(
    parameter int DATA_W = 16,
    parameter int WGT_W  = 16,
    parameter int TAPS   = 91,
    parameter int BEAMS  = 90,
    localparam int CPLX_W = DATA_W + WGT_W + 1,
    localparam int ACC_W  = CPLX_W + $clog2(TAPS),
    localparam int PWR_W  = 2 * ACC_W,
    localparam int IDX_W  = $clog2(BEAMS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_first,
    input  logic signed [DATA_W-1:0] smp_re,
    input  logic signed [DATA_W-1:0] smp_im,
    input  logic signed [WGT_W-1:0]  wgt_re,
    input  logic signed [WGT_W-1:0]  wgt_im,
    output logic                     out_valid,
    output logic [IDX_W-1:0]         out_idx,
    output logic signed [ACC_W-1:0]  out_re,
    output logic signed [ACC_W-1:0]  out_im,
    output logic [PWR_W-1:0]         out_pwr
);
    logic                     p_valid, p_first, done;
    logic signed [CPLX_W-1:0] p_re, p_im;
    logic signed [ACC_W-1:0]  beam_re, beam_im;
    logic [IDX_W-1:0]         beam_idx;

    bmac_cmul #(.DATA_W(DATA_W), .WGT_W(WGT_W)) u_cmul (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_first(in_first),
        .s_re(smp_re), .s_im(smp_im), .w_re(wgt_re), .w_im(wgt_im),
        .p_valid(p_valid), .p_first(p_first), .p_re(p_re), .p_im(p_im)
    );

    bmac_accum #(.CPLX_W(CPLX_W), .TAPS(TAPS), .BEAMS(BEAMS)) u_accum (
        .clk(clk), .rst_n(rst_n),
        .p_valid(p_valid), .p_first(p_first), .p_re(p_re), .p_im(p_im),
        .done(done), .beam_re(beam_re), .beam_im(beam_im), .beam_idx(beam_idx)
    );

    bmac_power #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_power (
        .clk(clk), .rst_n(rst_n),
        .done(done), .beam_re(beam_re), .beam_im(beam_im), .beam_idx(beam_idx),
        .out_valid(out_valid), .out_idx(out_idx),
        .out_re(out_re), .out_im(out_im), .out_pwr(out_pwr)
    );

    // Windows longer than one tap can never emit on adjacent cycles
    generate
        if (TAPS > 1) begin : g_spacing
            // R3
            pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |=> !out_valid);
        end
    endgenerate
endmodule

// File: tb/beam_mac_engine_bench.sv
// Bench: behavioural window model, compared against the outputs every clock.
module beam_mac_engine_bench;
    localparam int TAPS  = 91;
    localparam int BEAMS = 90;
    localparam int LAT   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_first = 1'b0;
    logic signed [15:0] smp_re = '0, smp_im = '0, wgt_re = '0, wgt_im = '0;
    logic out_valid;
    logic [6:0] out_idx;
    logic signed [39:0] out_re, out_im;
    logic [79:0] out_pwr;

    always #5 clk = ~clk;

    beam_mac_engine #(.TAPS(TAPS), .BEAMS(BEAMS)) u_beam_mac_engine (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .smp_re(smp_re), .smp_im(smp_im), .wgt_re(wgt_re), .wgt_im(wgt_im),
        .out_valid(out_valid), .out_idx(out_idx), .out_re(out_re),
        .out_im(out_im), .out_pwr(out_pwr)
    );

    typedef struct { bit v; longint re; longint im; int idx; } exp_t;
    exp_t q[$];

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    string cur = "R1";

    // model state
    bit     m_open = 0;
    int     m_cnt = 0, m_idx = 0;
    longint m_re = 0, m_im = 0;

    task automatic compare_front();
        exp_t e;
        logic signed [79:0] a, b;
        logic [79:0] pw;
        e = q.pop_front();
        n_tests++;
        if (out_valid !== e.v) begin
            n_fail++;
            $display("FAIL %s out_valid act=%0b exp=%0b", cur, out_valid, e.v);
        end
        if (e.v) begin
            a = e.re; b = e.im; pw = a * a + b * b;
            n_tests += 4;
            if (out_re !== 40'(e.re)) begin
                n_fail++; $display("FAIL %s out_re act=%0d exp=%0d", cur, out_re, e.re);
            end
            if (out_im !== 40'(e.im)) begin
                n_fail++; $display("FAIL %s out_im act=%0d exp=%0d", cur, out_im, e.im);
            end
            if (out_pwr !== pw) begin
                n_fail++; $display("FAIL R7 out_pwr act=%0d exp=%0d", out_pwr, pw);
            end
            if (out_idx !== 7'(e.idx)) begin
                n_fail++; $display("FAIL R8 out_idx act=%0d exp=%0d", out_idx, e.idx);
            end
        end
    endtask

    // one clock: check the due output, drive the next pair, update the model
    task automatic step(input bit v, input bit f, input logic signed [15:0] sr,
                        input logic signed [15:0] si, input logic signed [15:0] wr,
                        input logic signed [15:0] wi);
        exp_t e;
        longint pr, pi;
        @(negedge clk);
        if (q.size() == LAT) compare_front();
        in_valid = v; in_first = f;
        smp_re = sr; smp_im = si; wgt_re = wr; wgt_im = wi;
        e.v = 0; e.re = 0; e.im = 0; e.idx = 0;
        if (v) begin
            pr = longint'(sr) * longint'(wr) - longint'(si) * longint'(wi);
            pi = longint'(sr) * longint'(wi) + longint'(si) * longint'(wr);
            if (f) begin
                m_open = 1; m_cnt = 1; m_re = pr; m_im = pi;
            end else if (m_open) begin
                m_cnt++; m_re += pr; m_im += pi;
            end
            if (m_open && m_cnt == TAPS) begin
                e.v = 1; e.re = m_re; e.im = m_im; e.idx = m_idx;
                m_idx = (m_idx + 1) % BEAMS;
                m_open = 0;
            end
        end
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    function automatic logic signed [15:0] rnd();
        return 16'($urandom);
    endfunction

    task automatic rand_window(input int gap_every);
        for (int k = 0; k < TAPS; k++) begin
            if (gap_every > 0 && k % gap_every == 1) begin
                step(0, 1, rnd(), rnd(), rnd(), rnd()); // R10: flag without valid
                step(0, 0, rnd(), rnd(), rnd(), rnd());
            end
            step(1, k == 0, rnd(), rnd(), rnd(), rnd());
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset clears the outputs
        n_tests++;
        if (out_valid !== 0 || out_idx !== 0 || out_re !== 0 || out_im !== 0 || out_pwr !== 0) begin
            n_fail++;
            $display("FAIL R1 reset outputs act=%0b/%0d/%0d/%0d/%0d exp=0",
                     out_valid, out_idx, out_re, out_im, out_pwr);
        end
        rst_n = 1'b1;

        // R2 and R3: ramp data, single window, latency checked per clock
        cur = "R2";
        for (int k = 1; k <= TAPS; k++)
            step(1, k == 1, 16'(k), 16'(-k), 16'sd2, 16'sd3);
        cur = "R3";
        idle(8);

        // R5 and R10: stalls and stray flags inside a window
        cur = "R5";
        rand_window(3);
        idle(6);
        cur = "R10";
        rand_window(7);
        idle(6);

        // R6: valid pairs with no open window give no output
        cur = "R6";
        for (int k = 0; k < 2 * TAPS; k++) step(1, 0, rnd(), rnd(), rnd(), rnd());
        idle(6);

        // R4: restart in the middle of an open window
        cur = "R4";
        for (int k = 0; k < 40; k++) step(1, k == 0, rnd(), rnd(), rnd(), rnd());
        rand_window(0);
        idle(6);

        // R9: full-scale inputs on every tap
        cur = "R9";
        for (int k = 0; k < TAPS; k++) step(1, k == 0, -16'sd32768, -16'sd32768, -16'sd32768, 16'sd32767);
        for (int k = 0; k < TAPS; k++) step(1, k == 0, 16'sd32767, -16'sd32768, 16'sd32767, 16'sd32767);
        idle(6);

        // R8 and R7: back-to-back windows past one full snapshot (index wraps)
        cur = "R8";
        for (int w = 0; w < BEAMS + 5; w++) rand_window(0);
        idle(8);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog %s act=timeout exp=finish", cur);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule